// File: doc/BRIEF.md
# Bidirectional Strobed Handshake Port

This block joins a master processor and a slave bus through a single shared byte-wide data path. Each direction has its own latch. The slave pushes a byte into the input latch with a write strobe. The master takes that byte with a register read. The master pushes a byte into the output latch with a register write. The slave collects that byte by raising an acknowledge, and only during the acknowledge does the port drive the slave bus. Two buffer flags track the handshake: input-full and output-full, the second active-low.

Each flag has its own interrupt-enable flip-flop. The master sets or clears these enables with a single-bit set/reset write. The two enabled flags are merged into one interrupt request. The slave signals are assumed to be synchronous to the block clock. The tri-state bus is modelled as a data output plus an output-enable.

Top module: `hsk_bidir_port`

## Requirements
- R1: When `s_sel` is high and `s_wr_n` is low (strobe active), `s_din` is loaded into the input latch at the clock edge and `ibf` is 1 from the next cycle.
- R2: `s_oe` is 1 in exactly the cycles where `s_sel` is high and `s_rd_n` is low (acknowledge active), combinationally, and `s_dout` then shows the output latch.
- R3: With `s_sel` low, `s_wr_n` and `s_rd_n` have no effect: no load, no change of `ibf` or `obf_n`, and `s_oe` stays 0.
- R4: A master write (`m_cs`, `m_wr`, `m_addr`=0) stores `m_wdata` in the output latch and drives `obf_n` low from the next cycle.
- R5: `obf_n` returns to 1 in the cycle after the acknowledge goes inactive. It stays low while the acknowledge is active.
- R6: A master write to `m_addr`=3 is a bit set/reset. `m_wdata[3:1]` is the control-bit index and `m_wdata[0]` is the new value. Index 6 sets or clears the output interrupt enable, and index 4 sets or clears the input interrupt enable. All other indices change nothing.
- R7: A master read (`m_cs`, `m_rd`, `m_addr`=0) returns the input latch on `m_rdata` in the same cycle and clears `ibf` from the next cycle. A strobe in the same cycle wins, and `ibf` stays 1.
- R8: `intr` equals (`obf_n` AND output enable) OR (`ibf` AND input enable).
- R9: A read at `m_addr`=1 returns a status byte: bit 7 `obf_n`, bit 6 output enable, bit 5 `ibf`, bit 4 input enable, bit 3 `intr`, and 0 elsewhere. A read at `m_addr`=2 returns the output latch.
- R10: `ctl_lines` carries the control bits 4..7: [0] strobe (active low), [1] `ibf`, [2] acknowledge (active low), [3] `obf_n`.
- R11: After synchronous active-low reset: `ibf`=0, `obf_n`=1, both enables 0, `intr`=0, and both latches 0.
- R12: A master data write in the same cycle as the end of an acknowledge leaves `obf_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_cs | input | 1 | Master select |
| m_wr | input | 1 | Master write |
| m_rd | input | 1 | Master read |
| m_addr | input | 2 | Master register address |
| m_wdata | input | 8 | Master write data |
| m_rdata | output | 8 | Master read data (combinational) |
| s_sel | input | 1 | Slave select |
| s_wr_n | input | 1 | Slave write, active low |
| s_rd_n | input | 1 | Slave read, active low |
| s_din | input | 8 | Slave bus value in |
| s_dout | output | 8 | Value driven onto the slave bus |
| s_oe | output | 1 | Slave bus drive enable |
| ibf | output | 1 | Input buffer full |
| obf_n | output | 1 | Output buffer full, active low |
| intr | output | 1 | Interrupt request |
| ctl_lines | output | 4 | Control bits 4..7 as listed in R10 |

## Verification
The block has two kinds of result, and each has its own due time. `s_oe`, `s_dout`, `m_rdata`, `ctl_lines` and `intr` follow the current inputs and flags in the same cycle, so the bench checks them one time step after driving. The flags and enables change at the first clock edge after a strobe, master access or bit set/reset, and the flag release waits one further edge after the acknowledge ends. The bench drives inputs one time step after a rising edge and checks registered results right after the next edge. Its model of the flags and enables is updated at the same points.

// File: rtl/hsk_pkg.sv
// Shared constants of the handshake port: master register map and the
// control-bit indices used by the bit set/reset command.
package hsk_pkg;
    localparam logic [1:0] ADDR_DATA  = 2'd0;
    localparam logic [1:0] ADDR_STAT  = 2'd1;
    localparam logic [1:0] ADDR_OUTRB = 2'd2;
    localparam logic [1:0] ADDR_BSR   = 2'd3;

    localparam logic [2:0] IDX_INTE_IN  = 3'd4;
    localparam logic [2:0] IDX_INTE_OUT = 3'd6;

    // status byte bit positions
    localparam int ST_OBF_N    = 7;
    localparam int ST_INTE_OUT = 6;
    localparam int ST_IBF      = 5;
    localparam int ST_INTE_IN  = 4;
    localparam int ST_INTR     = 3;
endpackage

// File: rtl/hsk_in_path.sv
// Input direction: latch loaded by the slave strobe and a full flag
// cleared by the master read. Assumes strobe is synchronous to clk;
// a strobe in the same cycle as a master read takes priority.
module hsk_in_path #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic          take,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] latch_q,
    output logic          full
);
    // Load the latch on strobe; set or clear the full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            full    <= 1'b0;
        end else if (stb) begin
            latch_q <= din;
            full    <= 1'b1;
        end else if (take) begin
            full    <= 1'b0;
        end
    end
endmodule

// File: rtl/hsk_out_path.sv
// Output direction: latch written by the master, active-low full flag
// released one edge after the acknowledge goes inactive. A master write
// in the release cycle keeps the flag low.
module hsk_out_path #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] wdata,
    input  logic          ack,
    output logic [DW-1:0] latch_q,
    output logic          full_n
);
    logic ack_q;
    logic release_ev;

    // Detect the end of an acknowledge.
    assign release_ev = ack_q & ~ack;

    // Track the acknowledge of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= ack;
    end

    // Store master data and drive the full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            full_n  <= 1'b1;
        end else if (load) begin
            latch_q <= wdata;
            full_n  <= 1'b0;
        end else if (release_ev) begin
            full_n  <= 1'b1;
        end
    end
endmodule

// File: rtl/hsk_irq_ctl.sv
// Interrupt enables under bit set/reset control, and the merged request.
// Indices other than the two enable positions are ignored.
module hsk_irq_ctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bsr_wr,
    input  logic [2:0] bsr_idx,
    input  logic       bsr_val,
    input  logic       in_full,
    input  logic       out_full_n,
    output logic       inte_in,
    output logic       inte_out,
    output logic       intr
);
    import hsk_pkg::*;

    // Update the addressed enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inte_in  <= 1'b0;
            inte_out <= 1'b0;
        end else if (bsr_wr) begin
            if (bsr_idx == IDX_INTE_IN)  inte_in  <= bsr_val;
            if (bsr_idx == IDX_INTE_OUT) inte_out <= bsr_val;
        end
    end

    // Merge both enabled flag conditions.
    assign intr = (out_full_n & inte_out) | (in_full & inte_in);
endmodule

// File: rtl/hsk_bidir_port.sv
// Top of the handshake port: decodes master and slave accesses, joins the
// two data paths and the interrupt control, builds the read mux and the
// control-line view. Assumes all inputs are synchronous to clk.
module hsk_bidir_port #(
    parameter int DW = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m_cs,
    input  logic          m_wr,
    input  logic          m_rd,
    input  logic [AW-1:0] m_addr,
    input  logic [DW-1:0] m_wdata,
    output logic [DW-1:0] m_rdata,
    input  logic          s_sel,
    input  logic          s_wr_n,
    input  logic          s_rd_n,
    input  logic [DW-1:0] s_din,
    output logic [DW-1:0] s_dout,
    output logic          s_oe,
    output logic          ibf,
    output logic          obf_n,
    output logic          intr,
    output logic [3:0]    ctl_lines
);
    import hsk_pkg::*;

    logic          stb_act;
    logic          ack_act;
    logic          wr_data_ev;
    logic          rd_data_ev;
    logic          bsr_ev;
    logic [DW-1:0] in_latch;
    logic [DW-1:0] out_latch;
    logic          inte_in;
    logic          inte_out;
    logic [DW-1:0] status;

    // Decode slave strobe/acknowledge and master accesses.
    assign stb_act    = s_sel & ~s_wr_n;
    assign ack_act    = s_sel & ~s_rd_n;
    assign wr_data_ev = m_cs & m_wr & (m_addr == AW'(ADDR_DATA));
    assign rd_data_ev = m_cs & m_rd & (m_addr == AW'(ADDR_DATA));
    assign bsr_ev     = m_cs & m_wr & (m_addr == AW'(ADDR_BSR));

    hsk_in_path #(.DW(DW)) u_in (
        .clk(clk), .rst_n(rst_n), .stb(stb_act), .take(rd_data_ev),
        .din(s_din), .latch_q(in_latch), .full(ibf)
    );

    hsk_out_path #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n), .load(wr_data_ev), .wdata(m_wdata),
        .ack(ack_act), .latch_q(out_latch), .full_n(obf_n)
    );

    hsk_irq_ctl u_irq (
        .clk(clk), .rst_n(rst_n), .bsr_wr(bsr_ev),
        .bsr_idx(m_wdata[3:1]), .bsr_val(m_wdata[0]),
        .in_full(ibf), .out_full_n(obf_n),
        .inte_in(inte_in), .inte_out(inte_out), .intr(intr)
    );

    // Build the status byte.
    always_comb begin
        status              = '0;
        status[ST_OBF_N]    = obf_n;
        status[ST_INTE_OUT] = inte_out;
        status[ST_IBF]      = ibf;
        status[ST_INTE_IN]  = inte_in;
        status[ST_INTR]     = intr;
    end

    // Select master read data by address.
    always_comb begin
        case (m_addr)
            AW'(ADDR_DATA):  m_rdata = in_latch;
            AW'(ADDR_STAT):  m_rdata = status;
            AW'(ADDR_OUTRB): m_rdata = out_latch;
            default:         m_rdata = '0;
        endcase
    end

    // Drive the slave bus only while acknowledged.
    assign s_oe   = ack_act;
    assign s_dout = out_latch;

    // Control-line view of bits 4..7.
    assign ctl_lines = {obf_n, ~ack_act, ibf, ~stb_act};
endmodule

// File: rtl/hsk_bidir_port_chk.sv
// Assertion checker for hsk_bidir_port, attached by bind below.
module hsk_bidir_port_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          s_sel,
    input logic          s_wr_n,
    input logic          s_rd_n,
    input logic [DW-1:0] s_din,
    input logic          s_oe,
    input logic          ibf,
    input logic          obf_n,
    input logic          intr,
    input logic          wr_data_ev,
    input logic          rd_data_ev,
    input logic          ack_act,
    input logic [DW-1:0] in_latch
);
    p_stb_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_sel && !s_wr_n) |=> (ibf && in_latch == $past(s_din)));

    p_oe_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_sel && !s_rd_n) |-> s_oe);

    p_no_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !s_sel |-> !s_oe);

    p_obf_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_ev |=> !obf_n);

    p_obf_rel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ack_act) && !wr_data_ev) |=> obf_n);

    p_ibf_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_ev && !(s_sel && !s_wr_n)) |=> !ibf);

    p_intr_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> (ibf || obf_n));
endmodule

bind hsk_bidir_port hsk_bidir_port_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_sel(s_sel), .s_wr_n(s_wr_n),
    .s_rd_n(s_rd_n), .s_din(s_din), .s_oe(s_oe), .ibf(ibf),
    .obf_n(obf_n), .intr(intr), .wr_data_ev(wr_data_ev),
    .rd_data_ev(rd_data_ev), .ack_act(ack_act), .in_latch(in_latch)
);

// File: tb/tb_hsk_bidir_port.sv
module tb_hsk_bidir_port;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       m_cs, m_wr, m_rd;
    logic [1:0] m_addr;
    logic [7:0] m_wdata, m_rdata;
    logic       s_sel, s_wr_n, s_rd_n;
    logic [7:0] s_din, s_dout;
    logic       s_oe, ibf, obf_n, intr;
    logic [3:0] ctl_lines;

    int total = 0;
    int bad   = 0;
    bit e_ii = 0, e_io = 0;   // model of the enables
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsk_bidir_port dut (
        .clk(clk), .rst_n(rst_n), .m_cs(m_cs), .m_wr(m_wr), .m_rd(m_rd),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .s_sel(s_sel), .s_wr_n(s_wr_n), .s_rd_n(s_rd_n), .s_din(s_din),
        .s_dout(s_dout), .s_oe(s_oe), .ibf(ibf), .obf_n(obf_n),
        .intr(intr), .ctl_lines(ctl_lines)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        m_cs = 0; m_wr = 0; m_rd = 0; m_addr = 0; m_wdata = 0;
        s_sel = 0; s_wr_n = 1; s_rd_n = 1;
    endtask

    task automatic m_write(input logic [1:0] a, input logic [7:0] d);
        m_cs = 1; m_wr = 1; m_addr = a; m_wdata = d;
        step();
        m_cs = 0; m_wr = 0;
    endtask

    task automatic bsr(input int idx, input bit v);
        m_write(2'd3, 8'((idx << 1) | v));
        if (idx == 4) e_ii = v;
        if (idx == 6) e_io = v;
    endtask

    task automatic slave_wr(input logic [7:0] d);
        s_sel = 1; s_wr_n = 0; s_din = d;
        step();
        s_sel = 0; s_wr_n = 1;
    endtask

    task automatic chk_status(input string req);
        bit xi;
        m_addr = 2'd1; #1;
        xi = (obf_n & e_io) | (ibf & e_ii);
        chk({req, " intr"}, int'(intr), int'(xi));
        chk({req, " status"}, int'(m_rdata),
            int'({obf_n, e_io, ibf, e_ii, xi, 3'b000}));
        m_addr = 2'd0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(); s_din = 0; rst_n = 0;
        step(); step();
        rst_n = 1;
        // R11 reset state
        chk("R11 ibf", int'(ibf), 0);
        chk("R11 obf_n", int'(obf_n), 1);
        chk("R11 intr", int'(intr), 0);
        m_addr = 2'd2; #1;
        chk("R11 out latch", int'(m_rdata), 0);
        m_addr = 2'd0; #1;
        chk("R11 in latch", int'(m_rdata), 0);
        chk_status("R11");

        // R1/R7/R10 exhaustive input path sweep
        for (int v = 0; v < 256; v++) begin
            s_sel = 1; s_wr_n = 0; s_din = 8'(v); #1;
            chk("R10 strobe line", int'(ctl_lines[0]), 0);
            step();
            s_sel = 0; s_wr_n = 1; #1;
            chk("R1 ibf set", int'(ibf), 1);
            chk("R10 ibf line", int'(ctl_lines[1]), 1);
            m_cs = 1; m_rd = 1; m_addr = 0; #1;
            chk("R7 read data", int'(m_rdata), v);
            step();
            m_cs = 0; m_rd = 0;
            chk("R7 ibf cleared", int'(ibf), 0);
        end

        // R2/R4/R5/R9 exhaustive output path sweep
        for (int v = 0; v < 256; v++) begin
            m_write(2'd0, 8'(v));
            chk("R4 obf_n low", int'(obf_n), 0);
            chk("R10 obf line", int'(ctl_lines[3]), 0);
            m_addr = 2'd2; #1;
            chk("R9 out readback", int'(m_rdata), v);
            m_addr = 2'd0;
            chk("R2 no drive idle", int'(s_oe), 0);
            s_sel = 1; s_rd_n = 0; #1;
            chk("R2 drive on ack", int'(s_oe), 1);
            chk("R2 bus data", int'(s_dout), v);
            chk("R10 ack line", int'(ctl_lines[2]), 0);
            step();
            chk("R5 held during ack", int'(obf_n), 0);
            s_sel = 0; s_rd_n = 1; #1;
            chk("R2 drive off", int'(s_oe), 0);
            step();
            chk("R5 released", int'(obf_n), 1);
        end

        // R3 slave lines without select
        s_sel = 0; s_wr_n = 0; s_din = 8'hA5; #1;
        chk("R3 no oe", int'(s_oe), 0);
        step();
        s_wr_n = 1;
        chk("R3 ibf unchanged", int'(ibf), 0);
        #1 chk("R3 latch unchanged", int'(m_rdata), 255);
        m_write(2'd0, 8'h3C);
        s_rd_n = 0; #1;
        chk("R3 no oe on read", int'(s_oe), 0);
        step(); s_rd_n = 1; step();
        chk("R3 obf_n unchanged", int'(obf_n), 0);

        // R12 write in the cycle the acknowledge ends
        s_sel = 1; s_rd_n = 0; step();
        s_sel = 0; s_rd_n = 1;
        m_write(2'd0, 8'h5A);
        step();
        chk("R12 obf_n stays low", int'(obf_n), 0);
        s_sel = 1; s_rd_n = 0; #1;
        chk("R12 new data on bus", int'(s_dout), 8'h5A);
        step(); s_sel = 0; s_rd_n = 1; step();
        chk("R12 later release", int'(obf_n), 1);

        // R7 strobe wins over master read
        s_sel = 1; s_wr_n = 0; s_din = 8'h11; step();
        s_din = 8'h22; m_cs = 1; m_rd = 1; m_addr = 0; step();
        m_cs = 0; m_rd = 0; s_sel = 0; s_wr_n = 1; #1;
        chk("R7 strobe wins ibf", int'(ibf), 1);
        chk("R7 strobe wins data", int'(m_rdata), 8'h22);

        // R6/R8/R9 all indices and values, with both flag states
        for (int f = 0; f < 4; f++) begin
            // f[0]: ibf wanted, f[1]: output full (obf_n low) wanted
            if (ibf != f[0]) begin
                if (f[0]) slave_wr(8'(f));
                else begin m_cs = 1; m_rd = 1; step(); m_cs = 0; m_rd = 0; end
            end
            if ((!obf_n) != f[1]) begin
                if (f[1]) m_write(2'd0, 8'(f));
                else begin
                    s_sel = 1; s_rd_n = 0; step();
                    s_sel = 0; s_rd_n = 1; step();
                end
            end
            for (int idx = 0; idx < 8; idx++) begin
                for (int val = 1; val >= 0; val--) begin
                    bsr(idx, val[0]);
                    chk_status("R6 R8 R9");
                end
                bsr(4, 1); chk_status("R8 in enable");
                bsr(6, 1); chk_status("R8 both enables");
                bsr(4, 0); chk_status("R8 out enable");
                bsr(6, 0);
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule